// File: doc/BRIEF.md
# Bus-Activity Restarted Watchdog Timer

This block is a watchdog timer that a processor keeps alive through traffic on a two-wire serial bus instead of a dedicated kick pin. It samples the bus clock and data lines through two-flop synchronizers. It recognises start and stop conditions on the synchronized samples. A start condition that is later followed by a stop condition counts as one restart, and each restart reloads the timeout.

The timeout is counted in ticks of a tick-enable input, so the host can run the timer from any slow time base. A 2-bit period selector picks one of three periods or switches the timer off. When a period elapses without a restart, the active-low watchdog output is driven low for a fixed pulse length. In the same cycle a one-cycle fail strobe is sent toward a fault register. When the pulse ends, the timer reloads and counts a new period.

Top module: `bus_watchdog`

## Requirements
- R1: After reset, `wdo_n` is 1 and `wd_fail` is 0, and the timer starts in the off state.
- R2: A start condition is a falling edge of the synchronized data line while the synchronized clock line is high in both the current and the previous sample. Data edges while the clock line is low are neither starts nor stops. Stop conditions that no start preceded do not restart the timer.
- R3: A stop condition is a rising edge of the synchronized data line while the clock line stays high. A stop that follows a start reloads the timeout. A start that is never followed by a stop does not reload it.
- R4: `period_sel` encodes the period as follows: 2'b00 is LONG_TICKS, 2'b01 is MID_TICKS, 2'b10 is SHORT_TICKS and 2'b11 is off.
- R5: While `period_sel` is 2'b11, `wdo_n` stays 1 and `wd_fail` stays 0.
- R6: When the selected number of ticks passes without a restart, `wdo_n` goes to 0. When `tick_en` is held at 1, this happens on the clock edge that follows the reload edge by exactly that number of cycles.
- R7: `wdo_n` stays low for LONG_PULSE ticks in modes 2'b00 and 2'b01, and for SHORT_PULSE ticks in mode 2'b10.
- R8: `wd_fail` is a single-cycle pulse and is high exactly in the cycle in which `wdo_n` first reads 0.
- R9: When the pulse ends, `wdo_n` returns to 1 and a full new period starts from zero.
- R10: Any change of `period_sel` reloads the counter and ends a pulse in progress. Selecting 2'b11 raises `wdo_n` on the next clock edge.
- R11: The counter advances only in cycles with `tick_en` high. With `tick_en` low, neither the period nor the pulse progresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw serial bus clock line |
| sda_in | input | 1 | Raw serial bus data line |
| tick_en | input | 1 | Time base enable, one tick per high cycle |
| period_sel | input | 2 | Period selector (see R4) |
| wdo_n | output | 1 | Active-low watchdog output |
| wd_fail | output | 1 | One-cycle strobe to the fault register on expiry |

## Verification
On every cycle, the assertions check four things. The output stays high under the off code. The fail strobe lines up with the falling edge of `wdo_n` and lasts one cycle. Without a tick and without a selector change, the output cannot move. Only the bench's scenarios can show the exact expiry cycle for each period code, the pulse length for each mode, the reload after a pulse and after a selector change, and the difference between a proper start-then-stop sequence and lone stops, lone starts or data toggling while the clock line is low.

// File: rtl/bus_watchdog_pkg.sv
package bus_watchdog_pkg;
  typedef enum logic [1:0] {
    SEL_LONG  = 2'b00,
    SEL_MID   = 2'b01,
    SEL_SHORT = 2'b10,
    SEL_OFF   = 2'b11
  } wd_sel_e;

  typedef enum logic [1:0] {
    ST_OFF   = 2'b00,
    ST_COUNT = 2'b01,
    ST_FIRE  = 2'b10
  } wd_state_e;
endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);
  // Each line has its own shift chain; idle bus lines rest high.
  for (genvar b = 0; b < WIDTH; b++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], raw_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/bus_cond_detect.sv
module bus_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic restart_o
);
  logic scl_q, sda_q, armed_q, restart_q;
  logic start_c, stop_c;

  // Conditions need the clock line high on both samples around the data edge.
  assign start_c = scl_s && scl_q &&  sda_q && !sda_s;
  assign stop_c  = scl_s && scl_q && !sda_q &&  sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      armed_q   <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      scl_q     <= scl_s;
      sda_q     <= sda_s;
      restart_q <= stop_c && armed_q;
      if (start_c)     armed_q <= 1'b1;
      else if (stop_c) armed_q <= 1'b0;
    end
  end

  assign restart_o = restart_q;
endmodule

// File: rtl/wd_core.sv
module wd_core
  import bus_watchdog_pkg::*;
#(
  parameter int LONG_TICKS  = 1400,
  parameter int MID_TICKS   = 200,
  parameter int SHORT_TICKS = 25,
  parameter int LONG_PULSE  = 200,
  parameter int SHORT_PULSE = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [1:0] period_sel,
  input  logic       restart,
  output logic       wdo_n,
  output logic       wd_fail
);
  localparam int MAXV = (LONG_TICKS > LONG_PULSE) ? LONG_TICKS : LONG_PULSE;
  localparam int CW   = $clog2(MAXV + 1);
  localparam logic [CW-1:0] LONG_LIM  = CW'(LONG_TICKS - 1);
  localparam logic [CW-1:0] MID_LIM   = CW'(MID_TICKS - 1);
  localparam logic [CW-1:0] SHORT_LIM = CW'(SHORT_TICKS - 1);
  localparam logic [CW-1:0] LPUL_LIM  = CW'(LONG_PULSE - 1);
  localparam logic [CW-1:0] SPUL_LIM  = CW'(SHORT_PULSE - 1);

  wd_state_e     st_q;
  wd_sel_e       sel_c, sel_q;
  logic [CW-1:0] cnt_q, per_lim, pul_lim;
  logic          fail_q;

  assign sel_c = wd_sel_e'(period_sel);

  always_comb begin
    case (sel_q)
      SEL_LONG:  begin per_lim = LONG_LIM;  pul_lim = LPUL_LIM; end
      SEL_MID:   begin per_lim = MID_LIM;   pul_lim = LPUL_LIM; end
      SEL_SHORT: begin per_lim = SHORT_LIM; pul_lim = SPUL_LIM; end
      default:   begin per_lim = '0;        pul_lim = '0;       end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      sel_q  <= SEL_OFF;
      cnt_q  <= '0;
      fail_q <= 1'b0;
    end else begin
      fail_q <= 1'b0;
      sel_q  <= sel_c;
      if (sel_c == SEL_OFF) begin
        st_q  <= ST_OFF;
        cnt_q <= '0;
      end else if (sel_c != sel_q) begin
        st_q  <= ST_COUNT;
        cnt_q <= '0;
      end else begin
        case (st_q)
          ST_COUNT: begin
            if (restart) begin
              cnt_q <= '0;
            end else if (tick_en) begin
              if (cnt_q == per_lim) begin
                st_q   <= ST_FIRE;
                cnt_q  <= '0;
                fail_q <= 1'b1;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          ST_FIRE: begin
            if (tick_en) begin
              if (cnt_q == pul_lim) begin
                st_q  <= ST_COUNT;
                cnt_q <= '0;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          default: begin
            st_q  <= ST_COUNT;
            cnt_q <= '0;
          end
        endcase
      end
    end
  end

  assign wdo_n   = (st_q != ST_FIRE);
  assign wd_fail = fail_q;
endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog #(
  parameter int LONG_TICKS  = 1400,
  parameter int MID_TICKS   = 200,
  parameter int SHORT_TICKS = 25,
  parameter int LONG_PULSE  = 200,
  parameter int SHORT_PULSE = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       tick_en,
  input  logic [1:0] period_sel,
  output logic       wdo_n,
  output logic       wd_fail
);
  logic [1:0] lines_s;
  logic       restart;

  bus_line_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({scl_in, sda_in}),
    .sync_o (lines_s)
  );

  bus_cond_detect u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (lines_s[1]),
    .sda_s     (lines_s[0]),
    .restart_o (restart)
  );

  wd_core #(
    .LONG_TICKS  (LONG_TICKS),
    .MID_TICKS   (MID_TICKS),
    .SHORT_TICKS (SHORT_TICKS),
    .LONG_PULSE  (LONG_PULSE),
    .SHORT_PULSE (SHORT_PULSE)
  ) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .period_sel (period_sel),
    .restart    (restart),
    .wdo_n      (wdo_n),
    .wd_fail    (wd_fail)
  );
endmodule

// File: rtl/bus_watchdog_chk.sv
module bus_watchdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_en,
  input logic [1:0] period_sel,
  input logic       wdo_n,
  input logic       wd_fail
);
  // R5: off code keeps the output released
  p_off_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(period_sel) == 2'b11) |-> wdo_n);

  // R8: the strobe accompanies the falling edge of the output
  p_fail_marks_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdo_n) |-> wd_fail);

  // R8: strobe only while the output is low
  p_fail_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fail |-> !wdo_n);

  // R8: strobe lasts one cycle
  p_fail_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fail |=> !wd_fail);

  // R11: no tick and no selector change leaves the output unchanged
  p_hold_no_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && $stable(period_sel)) |=> $stable(wdo_n));
endmodule

bind bus_watchdog bus_watchdog_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .period_sel (period_sel),
  .wdo_n      (wdo_n),
  .wd_fail    (wd_fail)
);

// File: tb/bus_watchdog_test.sv
module bus_watchdog_test;
  localparam int TL = 40, TM = 24, TS = 16, PL = 8, PS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, tick = 1'b1;
  logic [1:0] sel = 2'b11;
  logic wdo_n, wd_fail;
  int n_chk = 0, n_bad = 0;
  logic saw_low;

  always #2 clk = ~clk;

  bus_watchdog #(.LONG_TICKS(TL), .MID_TICKS(TM), .SHORT_TICKS(TS),
                 .LONG_PULSE(PL), .SHORT_PULSE(PS)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
    .tick_en(tick), .period_sel(sel), .wdo_n(wdo_n), .wd_fail(wd_fail));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!wdo_n) saw_low = 1'b1;
    end
  endtask

  task automatic bus(input logic c, input logic d);
    scl = c; sda = d;
    cyc(1);
  endtask

  // negedges until wdo_n reads low
  task automatic delay_low(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (wdo_n && n < 2000);
  endtask

  task automatic go_off;
    sel = 2'b11;
    cyc(2);
  endtask

  task automatic t_reset;
    chk("R1 wdo_n after reset", wdo_n, 1);
    chk("R1 wd_fail after reset", wd_fail, 0);
    saw_low = 1'b0;
    cyc(100);
    chk("R5 off code never fires", saw_low, 0);
  endtask

  task automatic t_mode(input logic [1:0] code, input int per, input int pul, input string tag);
    int n, len;
    go_off();
    sel = code;
    delay_low(n);
    chk({"R6 R4 expiry cycle ", tag}, n, per + 1);
    chk({"R8 fail strobe at fall ", tag}, wd_fail, 1);
    len = 1;
    @(negedge clk);
    chk({"R8 strobe one cycle ", tag}, wd_fail, 0);
    while (!wdo_n && len < 2000) begin
      len++;
      @(negedge clk);
    end
    chk({"R7 pulse length ", tag}, len, pul);
    delay_low(n);
    chk({"R9 new period after pulse ", tag}, n, per);
    sel = 2'b11;
    @(negedge clk);
    chk({"R10 off ends pulse ", tag}, wdo_n, 1);
  endtask

  task automatic t_restart;
    go_off();
    sel = 2'b10;
    saw_low = 1'b0;
    for (int i = 0; i < 12; i++) begin
      bus(1, 1); bus(1, 0); bus(0, 0); bus(1, 0); bus(1, 1);
      cyc(5);
    end
    chk("R3 start then stop keeps timer alive", saw_low, 0);
  endtask

  task automatic t_stop_only;
    go_off();
    sel = 2'b10;
    saw_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      bus(0, 1); bus(0, 0); bus(1, 0); bus(1, 1); cyc(1);
    end
    chk("R2 lone stops do not restart", saw_low, 1);
  endtask

  task automatic t_start_only;
    go_off();
    sel = 2'b10;
    saw_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      bus(1, 1); bus(1, 0); bus(0, 0); bus(0, 1); bus(1, 1);
    end
    chk("R3 starts without stop do not restart", saw_low, 1);
  endtask

  task automatic t_low_toggle;
    go_off();
    sel = 2'b10;
    saw_low = 1'b0;
    scl = 1'b0;
    for (int i = 0; i < 20; i++) begin
      bus(0, 0); bus(0, 1);
    end
    scl = 1'b1; sda = 1'b1;
    cyc(2);
    chk("R2 data toggles with clock low ignored", saw_low, 1);
  endtask

  task automatic t_tick_gate;
    int n;
    go_off();
    tick = 1'b0;
    sel = 2'b10;
    saw_low = 1'b0;
    cyc(60);
    chk("R11 no ticks no expiry", saw_low, 0);
    tick = 1'b1;
    delay_low(n);
    chk("R11 expiry after ticks resume", n, TS);
    go_off();
  endtask

  task automatic t_reload;
    int n;
    go_off();
    sel = 2'b10;
    cyc(10);
    sel = 2'b01;
    delay_low(n);
    chk("R10 selector change reloads", n, TM + 1);
    go_off();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode(2'b10, TS, PS, "short");
    t_mode(2'b01, TM, PL, "mid");
    t_mode(2'b00, TL, PL, "long");
    t_restart();
    t_stop_only();
    t_start_only();
    t_low_toggle();
    t_tick_gate();
    t_reload();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule